// File: doc/BRIEF.md
# Field Event Interrupt Controller

This block sits on the host side of a video timing generator. It records each top-field and bottom-field event from the generator into a status register. It combines the pending events with a per-event enable mask and drives one level-sensitive interrupt line toward the host processor.

Software reaches the block through a small word-addressed register port. The port has four addresses, and every write to one of them changes only the bits written as 1, so no read-modify-write is ever needed. One address reads the pending status. Writes to that address change nothing. A second address clears status bits. A third clears enable bits. A fourth sets enable bits, and reading it returns the enable mask.

A typical bring-up clears everything through both clear addresses and then enables the two field events. The interrupt handler reads the status word and writes the same word to the status-clear address. A following status read confirms that the clear has landed.

Top module: `field_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, status, mask, `irq` and `reg_rdata` all become zero after that edge.
- R2: A 1 on `field_evt` bit i at a clock edge sets status bit i after that edge, and the bit holds until cleared. Bit 0 is the bottom-field event and bit 1 is the top-field event.
- R3: A write to address 1 (status clear) clears every status bit whose `reg_wdata` bit is 1. The other status bits keep their values.
- R4: A write to address 2 (mask clear) clears every mask bit whose `reg_wdata` bit is 1. The other mask bits keep their values.
- R5: A write to address 3 (mask set) sets every mask bit whose `reg_wdata` bit is 1. The other mask bits keep their values.
- R6: When an event and a status-clear write of the same bit fall on the same edge, the event wins and the bit ends up set.
- R7: Status bits latch whether or not they are enabled. The mask affects only `irq`.
- R8: `irq` is registered. After each edge it equals the OR over all bits of (status AND mask), taken from the values held before that edge.
- R9: A read is issued by `reg_rd` at an edge, and `reg_rdata` shows the result after that edge. Address 0 returns the status, zero-extended. Address 3 returns the mask, zero-extended. Addresses 1 and 2 return zero. When no read is issued, `reg_rdata` is zero. Because of this timing, a status read issued on the edge after a clear write returns the cleared value.
- R10: A write to address 0 changes neither status nor mask. Bits of `reg_wdata` above the event count have no effect.
- R11: Writing all ones to addresses 1 and 2 and then 3 (binary 11) to address 3 leaves the mask at 3 and the status at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| field_evt | input | NUM_EVT | Event pulses from the timing generator; bit 0 bottom field, bit 1 top field |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt to the host |

## Verification
Two things can land on the same status bit in the same cycle: a new field event from the generator, and a clear write from the host. The bench provokes this by driving an event pulse and a status-clear write of the same bit on one edge. It also provokes a neighbouring case, where one bit is cleared while another bit receives an event. A behavioural model in the bench gives the event priority. The model's irq and read data are compared with the design's on every cycle, and a later status read shows whether the bit survived.

// File: rtl/fei_pkg.sv
package fei_pkg;
  // Word offsets of the host-visible registers.
  localparam int unsigned OFS_STATUS   = 0;
  localparam int unsigned OFS_STAT_CLR = 1;
  localparam int unsigned OFS_MASK_CLR = 2;
  localparam int unsigned OFS_MASK_SET = 3;

  // Per-cycle register write strobes after address decode.
  typedef struct packed {
    logic stat_clr;
    logic mask_clr;
    logic mask_set;
  } fei_we_t;
endpackage

// File: rtl/fei_decode.sv
module fei_decode
  import fei_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output fei_we_t           we
);
  always_comb begin
    we.stat_clr = wr && (addr == ADDR_W'(OFS_STAT_CLR));
    we.mask_clr = wr && (addr == ADDR_W'(OFS_MASK_CLR));
    we.mask_set = wr && (addr == ADDR_W'(OFS_MASK_SET));
  end
endmodule

// File: rtl/fei_bitreg.sv
module fei_bitreg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // Each bit is an independent set/clear flop; set has priority.
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)           q_o[i] <= 1'b0;
      else if (set_i[i]) q_o[i] <= 1'b1;
      else if (clr_i[i]) q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/fei_readback.sv
module fei_readback
  import fei_pkg::*;
#(
  parameter int NUM_EVT = 2,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_EVT-1:0] stat,
  input  logic [NUM_EVT-1:0] mask,
  output logic [DATA_W-1:0]  rdata
);
  logic [DATA_W-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == ADDR_W'(OFS_STATUS))        sel = DATA_W'(stat);
    else if (addr == ADDR_W'(OFS_MASK_SET)) sel = DATA_W'(mask);
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= sel;
    else         rdata <= '0;
  end
endmodule

// File: rtl/field_irq_ctrl.sv
module field_irq_ctrl
  import fei_pkg::*;
#(
  parameter int NUM_EVT = 2,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] field_evt,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq
);
  fei_we_t            we;
  logic [NUM_EVT-1:0] wbits;
  logic [NUM_EVT-1:0] stat_q;
  logic [NUM_EVT-1:0] mask_q;
  logic [NUM_EVT-1:0] stat_clr;
  logic [NUM_EVT-1:0] mask_set;
  logic [NUM_EVT-1:0] mask_clr;

  assign wbits = reg_wdata[NUM_EVT-1:0];

  fei_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr   (reg_wr),
    .addr (reg_addr),
    .we   (we)
  );

  assign stat_clr = we.stat_clr ? wbits : '0;
  assign mask_set = we.mask_set ? wbits : '0;
  assign mask_clr = we.mask_clr ? wbits : '0;

  fei_bitreg #(.W(NUM_EVT)) u_status (
    .clk   (clk),
    .rst   (rst),
    .set_i (field_evt),
    .clr_i (stat_clr),
    .q_o   (stat_q)
  );

  fei_bitreg #(.W(NUM_EVT)) u_mask (
    .clk   (clk),
    .rst   (rst),
    .set_i (mask_set),
    .clr_i (mask_clr),
    .q_o   (mask_q)
  );

  fei_readback #(
    .NUM_EVT (NUM_EVT),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
  ) u_rb (
    .clk   (clk),
    .rst   (rst),
    .rd    (reg_rd),
    .addr  (reg_addr),
    .stat  (stat_q),
    .mask  (mask_q),
    .rdata (reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat_q & mask_q);
  end
endmodule

// File: rtl/fei_checker.sv
module fei_checker
  import fei_pkg::*;
#(
  parameter int NUM_EVT = 2,
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_EVT-1:0] field_evt,
  input logic               reg_wr,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic               irq,
  input logic [NUM_EVT-1:0] stat_q,
  input logic [NUM_EVT-1:0] mask_q
);
  logic [NUM_EVT-1:0] wd;
  assign wd = reg_wdata[NUM_EVT-1:0];

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (stat_q == '0) && (mask_q == '0) && !irq);

  // R2
  evt_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (|field_evt) |=> ((stat_q & $past(field_evt)) == $past(field_evt)));

  // R3
  stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(OFS_STAT_CLR))
      |=> stat_q == (($past(stat_q) & ~$past(wd)) | $past(field_evt)));

  // R4
  mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(OFS_MASK_CLR))
      |=> mask_q == ($past(mask_q) & ~$past(wd)));

  // R5
  mask_set_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(OFS_MASK_SET))
      |=> mask_q == ($past(mask_q) | $past(wd)));

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> irq == |($past(stat_q) & $past(mask_q)));

  // R10
  status_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == ADDR_W'(OFS_STATUS) && field_evt == '0)
      |=> $stable(stat_q) && $stable(mask_q));
endmodule

bind field_irq_ctrl fei_checker #(
  .NUM_EVT (NUM_EVT),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_fei_chk (
  .clk       (clk),
  .rst       (rst),
  .field_evt (field_evt),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq       (irq),
  .stat_q    (stat_q),
  .mask_q    (mask_q)
);

// File: tb/field_irq_ctrl_test.sv
`timescale 1ns/1ps
module field_irq_ctrl_test;
  localparam int NUM_EVT = 2;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 16;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NUM_EVT-1:0] field_evt = '0;
  logic               reg_wr = 1'b0;
  logic               reg_rd = 1'b0;
  logic [ADDR_W-1:0]  reg_addr = '0;
  logic [DATA_W-1:0]  reg_wdata = '0;
  logic [DATA_W-1:0]  reg_rdata;
  logic               irq;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // Reference state
  int m_stat = 0, m_mask = 0, m_irq = 0, m_rdata = 0;

  always #2 clk = ~clk;

  field_irq_ctrl #(.NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst(rst), .field_evt(field_evt), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // One clock: drive inputs, advance the model, compare after the edge.
  task automatic step(input int ev, input bit w, input bit r, input int a,
                      input int d, input string tag);
    int n_stat, n_mask, n_irq, n_rd, bits;
    field_evt = NUM_EVT'(ev);
    reg_wr    = w;
    reg_rd    = r;
    reg_addr  = ADDR_W'(a);
    reg_wdata = DATA_W'(d);
    bits = d & 3;
    if (rst) begin
      n_stat = 0; n_mask = 0; n_irq = 0; n_rd = 0;
    end else begin
      n_irq  = ((m_stat & m_mask) != 0) ? 1 : 0;
      n_rd   = !r ? 0 : (a == 0) ? m_stat : (a == 3) ? m_mask : 0;
      n_stat = m_stat;
      if (w && a == 1) n_stat = n_stat & ~bits;
      n_stat = (n_stat | ev) & 3;
      n_mask = m_mask;
      if (w && a == 2) n_mask = n_mask & ~bits;
      if (w && a == 3) n_mask = n_mask | bits;
    end
    @(posedge clk);
    #1;
    m_stat = n_stat; m_mask = n_mask; m_irq = n_irq; m_rdata = n_rd;
    vectors++;
    if (int'(irq) != m_irq || int'(reg_rdata) != m_rdata) begin
      fails++;
      $display("FAIL %s: irq=%0d rdata=%0h expected irq=%0d rdata=%0h",
               tag, irq, reg_rdata, m_irq, m_rdata);
    end
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, tag);
  endtask

  task automatic rd(input int a, input string tag);
    step(0, 0, 1, a, 0, tag);
  endtask

  task automatic wr(input int a, input int d, input string tag);
    step(0, 1, 0, a, d, tag);
  endtask

  initial begin
    int lfsr;
    @(negedge clk);
    rst = 1'b1;
    step(0, 0, 0, 0, 0, "R1");
    step(3, 1, 1, 3, 16'hffff, "R1");
    rst = 1'b0;
    rd(0, "R1"); rd(3, "R1"); idle("R1");

    // R2 / R7: events latch with mask off, irq stays low
    step(1, 0, 0, 0, 0, "R2"); rd(0, "R2");
    step(2, 0, 0, 0, 0, "R2"); rd(0, "R7"); idle("R7");

    // R3 partial clear, then read right after the clear (R9)
    wr(1, 16'h0001, "R3"); rd(0, "R9");
    wr(1, 16'h0002, "R3"); rd(0, "R3");
    rd(1, "R9"); rd(2, "R9");

    // R11 bring-up sequence
    step(3, 0, 0, 0, 0, "R11");
    wr(1, 16'hffff, "R11"); wr(2, 16'hffff, "R11"); wr(3, 16'h0003, "R11");
    rd(3, "R11"); rd(0, "R11");

    // R8: enabled event raises irq two cycles later
    step(2, 0, 0, 0, 0, "R8"); idle("R8"); idle("R8");
    wr(1, 16'h0002, "R8"); idle("R8"); idle("R8");

    // R6: event and clear of the same bit on one edge
    step(1, 1, 0, 1, 16'h0001, "R6"); rd(0, "R6"); idle("R6");
    step(2, 1, 0, 1, 16'h0001, "R6"); rd(0, "R6");

    // R4: dropping an enable drops irq while status persists
    wr(2, 16'h0001, "R4"); rd(3, "R4"); idle("R4");
    wr(2, 16'h0002, "R4"); idle("R4"); idle("R7"); rd(0, "R7");

    // R5: enabling an already pending bit raises irq
    wr(3, 16'h0002, "R5"); rd(3, "R5"); idle("R5"); idle("R5");

    // R10: status address writes and upper data bits are inert
    wr(0, 16'hffff, "R10"); rd(0, "R10");
    wr(1, 16'hfffc, "R10"); rd(0, "R10");
    wr(3, 16'hfffc, "R10"); rd(3, "R10");
    wr(2, 16'hfffc, "R10"); rd(3, "R10");

    // Mixed traffic
    lfsr = 32'h1d87;
    for (int i = 0; i < 400; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
      step((lfsr >> 3) & 3, ((lfsr >> 5) & 3) == 0, (lfsr >> 7) & 1,
           (lfsr >> 8) & 3, lfsr & 16'hffff, "R8");
    end
    wr(1, 16'hffff, "R3"); rd(0, "R3");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule